// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches the single tearing-effect line that a display panel drives back to its host. Horizontal and vertical sync pulses share that one line, and the block tells them apart by how long each pulse lasts, counted in ticks of a divided clock that arrives as a one-cycle tick enable. Vertical sync restarts a line count, and each horizontal sync advances it. From these events the block raises an active-low match pulse that tells the frame-transfer engine it may start pushing pixels without tearing.

Configuration comes in as static fields. These are a minimum horizontal width, a vertical width threshold in units of eight ticks, a polarity-invert bit for each sync type, a two-bit mode, a target line and a master enable. The consumer counts every falling edge of the match output as one event, so the block makes sure that each decision produces exactly one clean, fixed-length low pulse.

Top module: `te_sync_detect`

## Requirements
- R1: After reset `match_n` is 1. A pulse that is already active when the synchronized pin first becomes valid is not measured, because the block waits to see the line idle first.
- R2: The HS active level is `te_pin XOR hs_invert` and the VS active level is `te_pin XOR vs_invert`. With an invert bit at 1 that sync type is active low.
- R3: A pulse lasting at least `hs_width_cfg + 1` ticks and shorter than the VS threshold is an HS and advances the line count by one, saturating at its maximum. A shorter pulse is ignored.
- R4: A pulse lasting at least `(vs_width_cfg + 1) * 8` ticks is a VS and clears the line count to 0.
- R5: Pulse width is counted only in clock cycles where `tick_en` is 1.
- R6: With `mode` = 3 (vertical only), every VS yields one match and HS pulses yield none.
- R7: With `mode` = 2 (line), a match fires when an HS brings the line count to `target_line`, where the first HS after VS is line 1. With `target_line` = 0, the VS itself fires.
- R8: With `te_en` = 0, or `mode` equal to 0 or the reserved value 1, no match fires. After the block is enabled, line mode fires nothing until a VS has been seen.
- R9: Each match drives `match_n` low for exactly `MATCH_CYCLES` clocks and then high again, so there is one falling edge per event.
- R10: With `tick_en` held at 1, `match_n` falls at clock edge `SYNC_STAGES + 2`, where edge 1 is the first edge that samples the pin at its ending level.
- R11: The width counter saturates at its maximum and does not wrap, so an over-long pulse is still classified as VS.
- R12: In line mode a match fires at most once per frame. Further HS pulses in that frame do not fire, and a VS that arrives before the target is reached re-arms the count for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Divided-clock tick; widths are counted only when it is high |
| te_pin | input | 1 | Raw tearing-effect line from the panel |
| te_en | input | 1 | Master enable of the sync logic |
| mode | input | 2 | 0 off, 1 reserved (off), 2 line match, 3 vertical-only match |
| target_line | input | LINE_W | Line number that fires in line mode |
| hs_width_cfg | input | HS_FIELD_W | Minimum HS width minus one, in ticks |
| vs_width_cfg | input | VS_FIELD_W | VS threshold divided by eight, minus one |
| hs_invert | input | 1 | HS is active low when set |
| vs_invert | input | 1 | VS is active low when set |
| match_n | output | 1 | Active-low match pulse |

## Verification
On every cycle, the checker confirms that each low phase of `match_n` lasts exactly the programmed number of clocks, that no falling edge follows a cycle in which the block was disabled, and that in vertical-only mode every falling edge traces back to a classified VS. It also checks that a VS clears the line count, that an HS advances it by one, and that the width counters stop at their maximum. Only the directed scenarios can show the following: the exact latency from the pin, where the width boundaries fall, that only one match occurs per frame and the count re-arms, that tick gating stretches the measurement, and that each invert bit steers only its own sync type.

// File: rtl/te_pkg.sv
package te_pkg;

   typedef enum logic [1:0] {
      TE_OFF   = 2'd0,
      TE_RSVD  = 2'd1,
      TE_LINE  = 2'd2,
      TE_VSYNC = 2'd3
   } te_mode_e;

   localparam int TE_HS = 0;
   localparam int TE_VS = 1;
   localparam int TE_NUM_KINDS = 2;

   function automatic logic te_mode_active(input te_mode_e m);
      return (m == TE_LINE) || (m == TE_VSYNC);
   endfunction

endpackage

// File: rtl/te_pin_sync.sv
module te_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout,
   output logic valid
);

   logic [STAGES-1:0] sh_q;
   logic [STAGES-1:0] fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         fill_q <= '0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], din};
         fill_q <= {fill_q[STAGES-2:0], 1'b1};
      end
   end

   assign dout  = sh_q[STAGES-1];
   assign valid = fill_q[STAGES-1];

endmodule

// File: rtl/te_width_meter.sv
module te_width_meter #(
   parameter int WIDTH_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               tick,
   input  logic               act,
   output logic [WIDTH_W-1:0] run_cnt,
   output logic [WIDTH_W-1:0] width_q,
   output logic               done_q
);

   localparam logic [WIDTH_W-1:0] CNT_MAX = '1;

   logic ready_q;
   logic in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         in_q    <= 1'b0;
         run_cnt <= '0;
         width_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (en && tick) begin
            if (act) begin
               if (ready_q) begin
                  in_q <= 1'b1;
                  if (run_cnt != CNT_MAX)
                     run_cnt <= run_cnt + 1'b1;
               end
            end else begin
               ready_q <= 1'b1;
               if (in_q) begin
                  done_q  <= 1'b1;
                  width_q <= run_cnt;
               end
               in_q    <= 1'b0;
               run_cnt <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker
   import te_pkg::*;
#(
   parameter int LINE_W        = 11,
   parameter int WIDTH_W       = 12,
   parameter int HS_FIELD_W    = 3,
   parameter int VS_FIELD_W    = 9,
   parameter int VS_SCALE_LOG2 = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hs_done,
   input  logic [WIDTH_W-1:0]    hs_width,
   input  logic                  vs_done,
   input  logic [WIDTH_W-1:0]    vs_width,
   input  logic [HS_FIELD_W-1:0] hs_cfg,
   input  logic [VS_FIELD_W-1:0] vs_cfg,
   input  te_mode_e              mode,
   input  logic                  te_en,
   input  logic [LINE_W-1:0]     target,
   output logic                  hs_evt,
   output logic                  vs_evt,
   output logic [LINE_W-1:0]     line_q,
   output logic                  fire
);

   localparam int CMP_W = WIDTH_W + 1;
   localparam logic [LINE_W-1:0] LINE_MAX = '1;

   logic [CMP_W-1:0]  hs_min;
   logic [CMP_W-1:0]  vs_min;
   logic              enabled;
   logic              armed_q;
   logic [LINE_W-1:0] line_nx;

   always_comb begin
      hs_min  = CMP_W'(hs_cfg) + 1'b1;
      vs_min  = (CMP_W'(vs_cfg) + 1'b1) << VS_SCALE_LOG2;
      vs_evt  = vs_done && (CMP_W'(vs_width) >= vs_min);
      hs_evt  = hs_done && (CMP_W'(hs_width) >= hs_min)
                        && (CMP_W'(hs_width) <  vs_min);
      enabled = te_en && te_mode_active(mode);

      line_nx = line_q;
      if (vs_evt)
         line_nx = '0;
      else if (hs_evt && line_q != LINE_MAX)
         line_nx = line_q + 1'b1;

      fire = 1'b0;
      if (enabled) begin
         if (mode == TE_VSYNC)
            fire = vs_evt;
         else if (vs_evt)
            fire = (target == '0);
         else
            fire = hs_evt && armed_q && (line_nx == target);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         armed_q <= 1'b0;
      end else if (!enabled) begin
         line_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         line_q <= line_nx;
         if (vs_evt)
            armed_q <= !fire;
         else if (fire)
            armed_q <= 1'b0;
      end
   end

endmodule

// File: rtl/te_match_pulse.sv
module te_match_pulse #(
   parameter int MATCH_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic match_n
);

   localparam int CNT_W = $clog2(MATCH_CYCLES + 1);

   generate
      if (MATCH_CYCLES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) match_n <= 1'b1;
            else        match_n <= !fire;
         end
      end else begin : g_stretch
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] cnt_nx;
         always_comb begin
            if (fire)
               cnt_nx = CNT_W'(MATCH_CYCLES);
            else if (cnt_q != '0)
               cnt_nx = cnt_q - 1'b1;
            else
               cnt_nx = '0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q   <= '0;
               match_n <= 1'b1;
            end else begin
               cnt_q   <= cnt_nx;
               match_n <= (cnt_nx == '0);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
   import te_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int WIDTH_W       = 12,
   parameter int HS_FIELD_W    = 3,
   parameter int VS_FIELD_W    = 9,
   parameter int VS_SCALE_LOG2 = 3,
   parameter int LINE_W        = 11,
   parameter int MATCH_CYCLES  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_en,
   input  logic                  te_pin,
   input  logic                  te_en,
   input  logic [1:0]            mode,
   input  logic [LINE_W-1:0]     target_line,
   input  logic [HS_FIELD_W-1:0] hs_width_cfg,
   input  logic [VS_FIELD_W-1:0] vs_width_cfg,
   input  logic                  hs_invert,
   input  logic                  vs_invert,
   output logic                  match_n
);

   localparam int VS_MIN_TICKS = 1 << VS_SCALE_LOG2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("te_sync_detect: SYNC_STAGES must be at least 2");
      end
      if (VS_FIELD_W + VS_SCALE_LOG2 > WIDTH_W) begin : g_bad_vs
         $error("te_sync_detect: VS threshold does not fit the width counter");
      end
      if (HS_FIELD_W >= WIDTH_W) begin : g_bad_hs
         $error("te_sync_detect: HS field wider than the width counter");
      end
      if (MATCH_CYCLES < 1 || MATCH_CYCLES > VS_MIN_TICKS) begin : g_bad_match
         $error("te_sync_detect: MATCH_CYCLES must lie in 1..minimum VS width");
      end
   endgenerate

   logic pin_s;
   logic pin_ok;

   te_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (te_pin),
      .dout  (pin_s),
      .valid (pin_ok)
   );

   logic               kind_act  [TE_NUM_KINDS];
   logic [WIDTH_W-1:0] kind_cnt  [TE_NUM_KINDS];
   logic [WIDTH_W-1:0] kind_wid  [TE_NUM_KINDS];
   logic               kind_done [TE_NUM_KINDS];

   assign kind_act[TE_HS] = pin_s ^ hs_invert;
   assign kind_act[TE_VS] = pin_s ^ vs_invert;

   generate
      for (genvar k = 0; k < TE_NUM_KINDS; k++) begin : g_meter
         te_width_meter #(.WIDTH_W(WIDTH_W)) u_meter (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (pin_ok),
            .tick    (tick_en),
            .act     (kind_act[k]),
            .run_cnt (kind_cnt[k]),
            .width_q (kind_wid[k]),
            .done_q  (kind_done[k])
         );
      end
   endgenerate

   logic [WIDTH_W-1:0] hs_cnt;
   logic [WIDTH_W-1:0] vs_cnt;
   logic               hs_evt;
   logic               vs_evt;
   logic [LINE_W-1:0]  line_q;
   logic               fire;

   assign hs_cnt = kind_cnt[TE_HS];
   assign vs_cnt = kind_cnt[TE_VS];

   te_line_tracker #(
      .LINE_W        (LINE_W),
      .WIDTH_W       (WIDTH_W),
      .HS_FIELD_W    (HS_FIELD_W),
      .VS_FIELD_W    (VS_FIELD_W),
      .VS_SCALE_LOG2 (VS_SCALE_LOG2)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .hs_done  (kind_done[TE_HS]),
      .hs_width (kind_wid[TE_HS]),
      .vs_done  (kind_done[TE_VS]),
      .vs_width (kind_wid[TE_VS]),
      .hs_cfg   (hs_width_cfg),
      .vs_cfg   (vs_width_cfg),
      .mode     (te_mode_e'(mode)),
      .te_en    (te_en),
      .target   (target_line),
      .hs_evt   (hs_evt),
      .vs_evt   (vs_evt),
      .line_q   (line_q),
      .fire     (fire)
   );

   te_match_pulse #(.MATCH_CYCLES(MATCH_CYCLES)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .match_n (match_n)
   );

endmodule

// File: rtl/te_sync_detect_chk.sv
module te_sync_detect_chk #(
   parameter int LINE_W       = 11,
   parameter int WIDTH_W      = 12,
   parameter int MATCH_CYCLES = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               te_en,
   input logic [1:0]         mode,
   input logic               match_n,
   input logic               hs_evt,
   input logic               vs_evt,
   input logic [LINE_W-1:0]  line_q,
   input logic [WIDTH_W-1:0] hs_cnt,
   input logic [WIDTH_W-1:0] vs_cnt
);

   localparam logic [LINE_W-1:0]  LMAX = '1;
   localparam logic [WIDTH_W-1:0] WMAX = '1;
   localparam int RUN_W = $clog2(MATCH_CYCLES + 2);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= '0;
      else if (!match_n) run_q <= run_q + 1'b1;
      else               run_q <= '0;
   end

   a_r9_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      !match_n |-> run_q < RUN_W'(MATCH_CYCLES));

   a_r9_low_exact: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_n) |-> run_q == RUN_W'(MATCH_CYCLES));

   a_r8_fall_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(match_n) |-> ($past(te_en) && ($past(mode) == 2'd2 || $past(mode) == 2'd3)));

   a_r6_vsync_source: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(match_n) && $past(mode) == 2'd3) |-> $past(vs_evt));

   a_r4_vs_clears_line: assert property (@(posedge clk) disable iff (!rst_n)
      vs_evt |=> line_q == '0);

   a_r3_hs_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_evt && !vs_evt && te_en && (mode == 2'd2 || mode == 2'd3) && line_q != LMAX)
      |=> line_q == $past(line_q) + 1'b1);

   a_r11_hs_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_cnt == WMAX) |=> (hs_cnt == WMAX || hs_cnt == '0));

   a_r11_vs_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_cnt == WMAX) |=> (vs_cnt == WMAX || vs_cnt == '0));

endmodule

bind te_sync_detect te_sync_detect_chk #(
   .LINE_W       (LINE_W),
   .WIDTH_W      (WIDTH_W),
   .MATCH_CYCLES (MATCH_CYCLES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .te_en   (te_en),
   .mode    (mode),
   .match_n (match_n),
   .hs_evt  (hs_evt),
   .vs_evt  (vs_evt),
   .line_q  (line_q),
   .hs_cnt  (hs_cnt),
   .vs_cnt  (vs_cnt)
);

// File: tb/sim_te_sync_detect.sv
`timescale 1ns/1ps
module sim_te_sync_detect;

   localparam int LINE_W = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_en = 1'b1;
   logic              te_pin = 1'b0;
   logic              te_en = 1'b0;
   logic [1:0]        mode = 2'd0;
   logic [LINE_W-1:0] target_line = '0;
   logic [2:0]        hs_width_cfg = 3'd2;
   logic [8:0]        vs_width_cfg = 9'd1;
   logic              hs_invert = 1'b0;
   logic              vs_invert = 1'b0;
   logic              match_n;

   int  n_checks = 0;
   int  n_errors = 0;
   int  falls = 0;
   bit  pin_act = 1'b1;
   bit  tick_div = 1'b0;

   always #10 clk = ~clk;

   te_sync_detect u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en      (tick_en),
      .te_pin       (te_pin),
      .te_en        (te_en),
      .mode         (mode),
      .target_line  (target_line),
      .hs_width_cfg (hs_width_cfg),
      .vs_width_cfg (vs_width_cfg),
      .hs_invert    (hs_invert),
      .vs_invert    (vs_invert),
      .match_n      (match_n)
   );

   initial forever begin
      @(negedge match_n);
      if (rst_n) falls++;
   end

   initial forever begin
      @(negedge clk);
      tick_en = tick_div ? ~tick_en : 1'b1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // active phase of w cycles, then exact latency and event count checks
   task automatic pulse_exact(input int w, input int exp, input string req);
      int f0;
      te_pin = pin_act;
      repeat (w) @(negedge clk);
      te_pin = ~pin_act;
      f0 = falls;
      repeat (3) @(negedge clk);
      check(match_n == 1'b1, req, "match_n before latency edge", match_n, 1);
      @(negedge clk);
      check(match_n == !exp[0], req, "match_n at latency edge", match_n, !exp[0]);
      repeat (8) @(negedge clk);
      check(falls - f0 == exp, req, "match events", falls - f0, exp);
   endtask

   task automatic pulse_count(input int w, input int exp, input string req);
      int f0;
      te_pin = pin_act;
      repeat (w) @(negedge clk);
      te_pin = ~pin_act;
      f0 = falls;
      repeat (20) @(negedge clk);
      check(falls - f0 == exp, req, "match events", falls - f0, exp);
   endtask

   task automatic t_reset;
      te_pin = 1'b1; te_en = 1'b1; mode = 2'd3;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check(match_n == 1'b1, "R1", "match_n in reset", match_n, 1);
      rst_n = 1'b1;
      repeat (30) @(negedge clk);
      te_pin = 1'b0;
      repeat (12) @(negedge clk);
      check(falls == 0, "R1", "pulse active at start ignored", falls, 0);
      check(match_n == 1'b1, "R1", "match_n idle after reset", match_n, 1);
   endtask

   task automatic t_vsync_mode;
      mode = 2'd3; te_en = 1'b1;
      // R10: exact latency; R9: low for two clocks
      begin
         int f0;
         te_pin = 1'b1;
         repeat (20) @(negedge clk);
         te_pin = 1'b0;
         f0 = falls;
         repeat (3) @(negedge clk);
         check(match_n == 1'b1, "R10", "before edge 4", match_n, 1);
         @(negedge clk);
         check(match_n == 1'b0, "R10", "at edge 4", match_n, 0);
         @(negedge clk);
         check(match_n == 1'b0, "R9", "second low clock", match_n, 0);
         @(negedge clk);
         check(match_n == 1'b1, "R9", "high after two clocks", match_n, 1);
         repeat (6) @(negedge clk);
         check(falls - f0 == 1, "R6", "one event per VS", falls - f0, 1);
      end
      pulse_exact(4, 0, "R6");
      pulse_exact(4, 0, "R6");
      pulse_exact(20, 1, "R6");
   endtask

   task automatic t_line_mode;
      mode = 2'd2; te_en = 1'b1; target_line = 11'd3;
      pulse_exact(20, 0, "R7");
      pulse_exact(4, 0, "R7");
      pulse_exact(4, 0, "R7");
      pulse_exact(4, 1, "R7");
      pulse_exact(4, 0, "R12");
      pulse_exact(4, 0, "R12");
      pulse_exact(20, 0, "R12");
      pulse_exact(4, 0, "R12");
      pulse_exact(4, 0, "R12");
      pulse_exact(20, 0, "R12");
      pulse_exact(4, 0, "R12");
      pulse_exact(4, 0, "R12");
      pulse_exact(4, 1, "R12");
      target_line = 11'd0;
      pulse_exact(20, 1, "R7");
      pulse_exact(4, 0, "R7");
   endtask

   task automatic t_glitch;
      mode = 2'd2; te_en = 1'b1; target_line = 11'd2;
      pulse_exact(20, 0, "R3");
      pulse_exact(2, 0, "R3");
      pulse_exact(2, 0, "R3");
      pulse_exact(2, 0, "R3");
      pulse_exact(4, 0, "R3");
      pulse_exact(4, 1, "R3");
   endtask

   task automatic t_boundary;
      mode = 2'd2; target_line = 11'd1;
      pulse_exact(20, 0, "R3");
      pulse_exact(3, 1, "R3");
      mode = 2'd3;
      pulse_exact(15, 0, "R4");
      pulse_exact(16, 1, "R4");
   endtask

   task automatic t_disable;
      te_en = 1'b0; mode = 2'd3;
      pulse_exact(20, 0, "R8");
      te_en = 1'b1; mode = 2'd1;
      pulse_exact(20, 0, "R8");
      mode = 2'd0;
      pulse_exact(20, 0, "R8");
      mode = 2'd2; target_line = 11'd1;
      pulse_exact(4, 0, "R8");
      pulse_exact(20, 0, "R8");
      pulse_exact(4, 1, "R8");
   endtask

   task automatic t_polarity;
      mode = 2'd3; te_en = 1'b1;
      te_pin = 1'b1; hs_invert = 1'b1; vs_invert = 1'b1; pin_act = 1'b0;
      repeat (6) @(negedge clk);
      pulse_exact(20, 1, "R2");
      te_pin = 1'b1; hs_invert = 1'b0; vs_invert = 1'b1;
      repeat (6) @(negedge clk);
      pulse_exact(20, 1, "R2");
      te_pin = 1'b0; hs_invert = 1'b1; vs_invert = 1'b0; pin_act = 1'b1;
      repeat (6) @(negedge clk);
      pulse_exact(20, 1, "R2");
      te_pin = 1'b0; hs_invert = 1'b0; vs_invert = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic t_tick;
      mode = 2'd3; te_en = 1'b1;
      tick_div = 1'b1;
      repeat (4) @(negedge clk);
      pulse_count(20, 0, "R5");
      pulse_count(34, 1, "R5");
      tick_div = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_saturate;
      mode = 2'd3; te_en = 1'b1;
      pulse_exact(4100, 1, "R11");
   endtask

   initial begin
      fork
         begin
            @(negedge clk);
            t_reset;
            t_vsync_mode;
            t_line_mode;
            t_glitch;
            t_boundary;
            t_disable;
            t_polarity;
            t_tick;
            t_saturate;
         end
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "R1", "watchdog expired", 0, 1);
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule